// File: doc/BRIEF.md
# Test-Mode Register Bus Controller

This block is the register-access glue for the I/O window `$4000`-`$401F` of a console CPU. For each CPU read it decides whether an internal register answers, in which case the block drives the data pins and supplies the byte, or whether the external bus answers. It also produces the joypad read and write strobes and the bus clock pin, together with that pin's output enable.

A test pin changes how the window behaves. The pin is cleaned up by a two-flop synchroniser. Once its synchronised level is high, every address in the window is decoded internally. Joypad reads still strobe, but they return the chip's internal open-bus byte instead of the external data. Three debug registers become live: readback of the sound channel output levels, a channel-freeze flag, and a triangle sequence position load. The test level also decides whether the bus clock pin stays driven while reset is asserted.

The bus clock pin is derived from a phase count that an external divider supplies. It rises a fixed number of master-clock edges before internal phase 2 rises, and both fall together.

Top module: `regbus_testctl`

## Requirements
- R1: When test mode is off, a read of `$4015` asserts `data_oe` and returns `apu_stat` on `cpu_rdata`.
- R2: When test mode is off, a read of any other window address leaves `data_oe` low, and `cpu_rdata` equals `ext_rdata`.
- R3: An access outside `$4000`-`$401F` never asserts `data_oe`, and `cpu_rdata` equals `ext_rdata`.
- R4: When test mode is on, a read of any window address asserts `data_oe`. `$4015` returns `apu_stat`. Addresses that have no readback source return `open_bus`.
- R5: A read of `$4016` asserts `joy1_rd` and a read of `$4017` asserts `joy2_rd`, in either mode. When test mode is on, the returned byte is `open_bus` and `ext_rdata` is ignored.
- R6: When test mode is on, reading `$4018` returns `{pulse2_lvl, pulse1_lvl}` (pulse 2 in bits 7:4). Reading `$4019` returns `{noise_lvl, tri_lvl}` (noise in bits 7:4). Reading `$401A` returns `{1'b0, dmc_lvl}`.
- R7: When test mode is on, a write to `$401A` loads `cpu_wdata[4:0]` into `tri_pos` and `cpu_wdata[7]` into `chan_freeze` on the ending clock edge. `tri_ld` is high for exactly the cycle after that edge.
- R8: When test mode is off, writes to `$4018`-`$401A` leave `chan_freeze` and `tri_pos` unchanged and do not raise `tri_ld`.
- R9: `joy_wr` is high exactly for writes to `$4016`, in either mode.
- R10: Test mode is the level of `test_pin` as captured by two successive clock edges. A change on the pin does not affect decoding until the second edge.
- R11: `bus_clk_oe` is high whenever `rst_n` is high. While `rst_n` is low, `bus_clk_oe` equals the synchronised test level.
- R12: `ph2` is high for `cyc_pos` from 6 to 11. `bus_clk` is high for `cyc_pos` from 3 to 11, which is three master-clock edges earlier. Both are low from `cyc_pos` 0.
- R13: Reset clears `chan_freeze`, `tri_pos` and `tri_ld` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_pin | input | 1 | Raw test-mode pin |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| ext_rdata | input | 8 | Data driven by external devices |
| open_bus | input | 8 | Internal last-bus-value latch |
| apu_stat | input | 8 | Sound status register value |
| pulse1_lvl | input | 4 | Pulse 1 output level |
| pulse2_lvl | input | 4 | Pulse 2 output level |
| tri_lvl | input | 4 | Triangle output level |
| noise_lvl | input | 4 | Noise output level |
| dmc_lvl | input | 7 | Sample channel output level |
| cyc_pos | input | 4 | Synchronised phase count, 0 to 11 |
| cpu_rdata | output | 8 | Data seen by the CPU |
| data_oe | output | 1 | Data pins driven by the chip |
| joy1_rd | output | 1 | Joypad 1 read strobe |
| joy2_rd | output | 1 | Joypad 2 read strobe |
| joy_wr | output | 1 | Joypad write strobe |
| chan_freeze | output | 1 | Freeze all sound channels |
| tri_pos | output | 5 | Triangle sequence position |
| tri_ld | output | 1 | Triangle position load pulse |
| bus_clk | output | 1 | Bus clock pin level |
| bus_clk_oe | output | 1 | Bus clock pin driven |
| ph2 | output | 1 | Internal phase-2 clock |

## Verification
The bus results are due in the same cycle as the stimulus: `cpu_rdata`, `data_oe`, the joypad strobes, `bus_clk` and `ph2` are checked shortly after inputs change at a falling edge, before the next rising edge. The debug registers and `tri_ld` are due one rising edge after the write, so they are compared at the next falling edge. A change on the test pin counts only after two rising edges. The bench therefore keeps its own two-stage copy of the pin level and uses that copy to pick the expected decoding for every access.

// File: rtl/regbus_testctl.sv
module regbus_testctl #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int LVL_W  = 4,
  parameter int DMC_W  = 7,
  parameter int POS_W  = 5,
  parameter int CYC_W  = 4,
  parameter int PH2_AT = 6,
  parameter int LEAD   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_pin,
  input  logic [AW-1:0]    cpu_addr,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic [DW-1:0]    ext_rdata,
  input  logic [DW-1:0]    open_bus,
  input  logic [DW-1:0]    apu_stat,
  input  logic [LVL_W-1:0] pulse1_lvl,
  input  logic [LVL_W-1:0] pulse2_lvl,
  input  logic [LVL_W-1:0] tri_lvl,
  input  logic [LVL_W-1:0] noise_lvl,
  input  logic [DMC_W-1:0] dmc_lvl,
  input  logic [CYC_W-1:0] cyc_pos,
  output logic [DW-1:0]    cpu_rdata,
  output logic             data_oe,
  output logic             joy1_rd,
  output logic             joy2_rd,
  output logic             joy_wr,
  output logic             chan_freeze,
  output logic [POS_W-1:0] tri_pos,
  output logic             tri_ld,
  output logic             bus_clk,
  output logic             bus_clk_oe,
  output logic             ph2
);
  localparam int WIN_BITS = 5;
  localparam logic [AW-1:0] WIN_BASE = AW'(16'h4000);
  localparam logic [WIN_BITS-1:0] OFF_STAT = 5'h15;
  localparam logic [WIN_BITS-1:0] OFF_JOY1 = 5'h16;
  localparam logic [WIN_BITS-1:0] OFF_JOY2 = 5'h17;
  localparam logic [WIN_BITS-1:0] OFF_PLS  = 5'h18;
  localparam logic [WIN_BITS-1:0] OFF_TNS  = 5'h19;
  localparam logic [WIN_BITS-1:0] OFF_DBG  = 5'h1A;
  localparam logic [CYC_W-1:0] CLK_UP = CYC_W'(PH2_AT - LEAD);
  localparam logic [CYC_W-1:0] PH2_UP = CYC_W'(PH2_AT);

  logic test_m, test_q;
  always_ff @(posedge clk) begin
    test_m <= test_pin;
    test_q <= test_m;
  end

  logic in_win;
  logic [WIN_BITS-1:0] off;
  assign in_win = cpu_addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS];
  assign off    = cpu_addr[WIN_BITS-1:0];

  logic hit_stat, hit_int;
  assign hit_stat = in_win && off == OFF_STAT;
  assign hit_int  = hit_stat || (test_q && in_win);

  assign data_oe = cpu_rd && hit_int;

  logic [DW-1:0] int_data;
  always_comb begin
    int_data = open_bus;
    if (hit_stat)
      int_data = apu_stat;
    else if (off == OFF_PLS)
      int_data = {pulse2_lvl, pulse1_lvl};
    else if (off == OFF_TNS)
      int_data = {noise_lvl, tri_lvl};
    else if (off == OFF_DBG)
      int_data = {{(DW-DMC_W){1'b0}}, dmc_lvl};
  end

  assign cpu_rdata = data_oe ? int_data : ext_rdata;

  assign joy1_rd = cpu_rd && in_win && off == OFF_JOY1;
  assign joy2_rd = cpu_rd && in_win && off == OFF_JOY2;
  assign joy_wr  = cpu_wr && in_win && off == OFF_JOY1;

  logic dbg_wr;
  assign dbg_wr = cpu_wr && test_q && in_win && off == OFF_DBG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_freeze <= 1'b0;
      tri_pos     <= '0;
      tri_ld      <= 1'b0;
    end else begin
      tri_ld <= dbg_wr;
      if (dbg_wr) begin
        chan_freeze <= cpu_wdata[DW-1];
        tri_pos     <= cpu_wdata[POS_W-1:0];
      end
    end
  end

  assign ph2        = cyc_pos >= PH2_UP;
  assign bus_clk    = cyc_pos >= CLK_UP;
  assign bus_clk_oe = rst_n || test_q;
endmodule

// File: rtl/regbus_testctl_chk.sv
module regbus_testctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        test_q,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_wdata,
  input logic        data_oe,
  input logic        chan_freeze,
  input logic [4:0]  tri_pos,
  input logic        tri_ld,
  input logic        bus_clk,
  input logic        bus_clk_oe,
  input logic        ph2
);
  logic win;
  assign win = cpu_addr[15:5] == 11'h200;

  a_r3_no_oe_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> !data_oe);

  a_r4_test_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q && cpu_rd && win) |-> data_oe);

  a_r7_dbg_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && test_q && cpu_addr == 16'h401A) |=>
      (tri_ld && tri_pos == $past(cpu_wdata[4:0]) && chan_freeze == $past(cpu_wdata[7])));

  a_r8_dbg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !test_q && cpu_addr == 16'h401A) |=>
      (!tri_ld && $stable(tri_pos) && $stable(chan_freeze)));

  a_r12_clk_leads: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |-> bus_clk);

  a_r11_oe_run: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_oe);
endmodule

bind regbus_testctl regbus_testctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .test_q(test_q), .cpu_addr(cpu_addr),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .data_oe(data_oe),
  .chan_freeze(chan_freeze), .tri_pos(tri_pos), .tri_ld(tri_ld),
  .bus_clk(bus_clk), .bus_clk_oe(bus_clk_oe), .ph2(ph2)
);

// File: tb/test_regbus_testctl.sv
module test_regbus_testctl;
  logic clk = 1'b0;
  logic rst_n, test_pin, cpu_rd, cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0] cpu_wdata, ext_rdata, open_bus, apu_stat;
  logic [3:0] pulse1_lvl, pulse2_lvl, tri_lvl, noise_lvl, cyc_pos;
  logic [6:0] dmc_lvl;
  logic [7:0] cpu_rdata;
  logic data_oe, joy1_rd, joy2_rd, joy_wr, chan_freeze, tri_ld, bus_clk, bus_clk_oe, ph2;
  logic [4:0] tri_pos;

  regbus_testctl i_regbus_testctl (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic m1 = 1'b0, m2 = 1'b0;
  logic e_frz = 1'b0, e_ld = 1'b0;
  logic [4:0] e_pos = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return a[15:5] == 11'h200;
  endfunction

  function automatic bit exp_oe(input logic [15:0] a, input logic rd, input logic tq);
    return rd && in_win(a) && (a == 16'h4015 || tq);
  endfunction

  function automatic logic [7:0] exp_data(input logic [15:0] a, input logic rd, input logic tq);
    if (!exp_oe(a, rd, tq)) return ext_rdata;
    case (a)
      16'h4015: return apu_stat;
      16'h4018: return {pulse2_lvl, pulse1_lvl};
      16'h4019: return {noise_lvl, tri_lvl};
      16'h401A: return {1'b0, dmc_lvl};
      default:  return open_bus;
    endcase
  endfunction

  // one cycle: account for the rising edge just passed, then apply new inputs
  task automatic step(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    if (!rst_n) begin
      e_frz = 0; e_pos = 0; e_ld = 0;
    end else begin
      e_ld = cpu_wr && m2 && cpu_addr == 16'h401A;
      if (e_ld) begin e_frz = cpu_wdata[7]; e_pos = cpu_wdata[4:0]; end
    end
    m2 = m1; m1 = test_pin;
    chk(tri_ld == e_ld, "R7/R8 tri_ld", tri_ld, e_ld);
    chk(tri_pos == e_pos, "R7/R8/R13 tri_pos", tri_pos, e_pos);
    chk(chan_freeze == e_frz, "R7/R8/R13 chan_freeze", chan_freeze, e_frz);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    ext_rdata = 8'($urandom); open_bus = 8'($urandom); apu_stat = 8'($urandom);
    pulse1_lvl = 4'($urandom); pulse2_lvl = 4'($urandom);
    tri_lvl = 4'($urandom); noise_lvl = 4'($urandom); dmc_lvl = 7'($urandom);
    cyc_pos = 4'($urandom_range(11));
    #1;
    chk(data_oe == exp_oe(a, rd, m2), "R1/R2/R3/R4 data_oe", data_oe, exp_oe(a, rd, m2));
    chk(cpu_rdata == exp_data(a, rd, m2), "R1/R2/R4/R5/R6 cpu_rdata", cpu_rdata, exp_data(a, rd, m2));
    chk(joy1_rd == (rd && a == 16'h4016), "R5 joy1_rd", joy1_rd, rd && a == 16'h4016);
    chk(joy2_rd == (rd && a == 16'h4017), "R5 joy2_rd", joy2_rd, rd && a == 16'h4017);
    chk(joy_wr == (wr && a == 16'h4016), "R9 joy_wr", joy_wr, wr && a == 16'h4016);
    chk(ph2 == (cyc_pos >= 6), "R12 ph2", ph2, cyc_pos >= 6);
    chk(bus_clk == (cyc_pos >= 3), "R12 bus_clk", bus_clk, cyc_pos >= 3);
    chk(bus_clk_oe == (rst_n || m2), "R11 bus_clk_oe", bus_clk_oe, rst_n || m2);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; test_pin = 0; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
    ext_rdata = '0; open_bus = '0; apu_stat = '0; pulse1_lvl = '0; pulse2_lvl = '0;
    tri_lvl = '0; noise_lvl = '0; dmc_lvl = '0; cyc_pos = '0;
    // R11/R13: reset with test low, then with test high
    repeat (4) step(16'h0000, 0, 0, 0);
    chk(bus_clk_oe == 1'b0, "R11 tri-state in reset", bus_clk_oe, 0);
    test_pin = 1;
    step(16'h0000, 0, 0, 0);
    chk(bus_clk_oe == 1'b0, "R10 one edge not enough", bus_clk_oe, 0);
    step(16'h0000, 0, 0, 0);
    chk(bus_clk_oe == 1'b1, "R10/R11 driven in reset", bus_clk_oe, 1);
    chk(tri_pos == 0 && !chan_freeze && !tri_ld, "R13 reset state", tri_pos, 0);
    rst_n = 1; test_pin = 0;
    repeat (3) step(16'h0000, 0, 0, 0);
    // directed, normal mode
    step(16'h4015, 1, 0, 0);              // R1
    step(16'h4016, 1, 0, 0);              // R2 R5
    step(16'h4018, 1, 0, 0);              // R2
    step(16'h401A, 0, 1, 8'h9F);          // R8
    step(16'h4016, 0, 1, 8'h01);          // R9
    step(16'h2002, 1, 0, 0);              // R3
    // test mode
    test_pin = 1;
    step(16'h4019, 1, 0, 0);              // R10: still normal
    step(16'h4019, 1, 0, 0);
    step(16'h4019, 1, 0, 0);              // R6
    step(16'h4018, 1, 0, 0);              // R6
    step(16'h401A, 1, 0, 0);              // R6
    step(16'h4017, 1, 0, 0);              // R5 open bus
    step(16'h4000, 1, 0, 0);              // R4
    step(16'h401A, 0, 1, 8'h9F);          // R7
    step(16'h401A, 0, 1, 8'h13);          // R7
    step(16'h4100, 1, 0, 0);              // R3
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic rd, wr;
      if ($urandom_range(99) < 3) test_pin = ~test_pin;
      a = ($urandom_range(9) == 0) ? 16'($urandom) : (16'h4000 | 16'($urandom_range(31)));
      rd = 1'($urandom); wr = !rd && 1'($urandom);
      step(a, rd, wr, 8'($urandom));
    end
    rst_n = 0;
    step(16'h0000, 0, 0, 0);              // R13 clears
    step(16'h0000, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule